// File: doc/BRIEF.md
# Debug Memory Access Arbiter with Cycle Stealing

This block lets a debug host read and write memory while the processor keeps executing. A request is accepted on a valid/ready port. The block holds that one request and watches the core's bus-idle indication. The access goes onto the shared memory bus in the first cycle the core leaves the bus free. The core is not disturbed in that case.

The core may keep the bus busy. After a fixed waiting window the block stalls the core for a single cycle and takes the bus. An address in the off-chip region needs no waiting: it takes the bus in its first pending cycle and stalls the core only if the core is busy in that cycle. While the debug-mode input is high, a small bank of debug registers appears at the very top of the address space. Accesses to that bank never touch the bus. Each access completes with a one-cycle response pulse in the cycle after it is performed, and read data travels with that pulse.

Top module: `dbgarb_top`

## Requirements
- R1: A request is accepted in a cycle where req_valid and req_ready are both high. req_ready is low from the cycle after acceptance through the cycle in which the access is performed. Request inputs presented during that time are ignored.
- R2: For an on-chip address (below 0xC000, outside the register window), the access is performed in the first pending cycle in which core_bus_idle is high, counted from the cycle after acceptance. In that cycle bus_en is 1 and core_stall is 0.
- R3: If an on-chip request has waited 128 pending cycles without an idle cycle, it is performed in the next pending cycle. That is the 129th pending cycle after acceptance.
- R4: An off-chip address (0xC000 and above, outside the active register window) is performed in the first pending cycle, whatever the state of core_bus_idle.
- R5: core_stall is high only in a cycle where bus_en is high and core_bus_idle is low, and it never stays high for two cycles in a row.
- R6: rsp_valid is high for exactly one cycle, the cycle after the access is performed. For a read, rsp_rdata then carries the word read: bus_rdata as seen in the access cycle, or the register content.
- R7: While bus_en is high, bus_addr, bus_wdata and bus_we carry the address, write data and write flag captured at acceptance. bus_we is 1 only for writes.
- R8: When dbg_mode is high at acceptance, addresses 0xFFF8 to 0xFFFF select eight debug registers, indexed by the low three address bits. Such an access is performed in the first pending cycle with bus_en and core_stall both 0. Registers reset to zero.
- R9: When dbg_mode is low at acceptance, addresses 0xFFF8 to 0xFFFF are ordinary off-chip bus accesses.
- R10: During and right after synchronous reset, req_ready is 1, and rsp_valid, bus_en and core_stall are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dbg_mode | input | 1 | Enables the debug register window, sampled at acceptance |
| req_valid | input | 1 | Debug request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 16 | Request word address |
| req_wdata | input | 16 | Write data |
| req_write | input | 1 | 1 = write, 0 = read |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, valid with rsp_valid on reads |
| core_bus_idle | input | 1 | Core leaves the bus unused this cycle |
| core_stall | output | 1 | Core must hold off for this cycle |
| bus_en | output | 1 | Debug side drives the memory bus this cycle |
| bus_we | output | 1 | Bus write strobe |
| bus_addr | output | 16 | Bus address |
| bus_wdata | output | 16 | Bus write data |
| bus_rdata | input | 16 | Bus read data, valid in the access cycle |

## Verification
Bus ownership and the stall are combinational on core_bus_idle within a pending cycle. They are due in the same cycle as the idle input that triggers them, so the bench drives inputs on the falling edge and compares a few nanoseconds later. The response pulse and its read data are registered and fall due exactly one cycle after the access. The reference model carries them over one clock edge before comparing. The timeout case counts pending cycles in the model and expects the bus grant on pending cycle 129, never earlier or later.

// File: rtl/dbgarb_pkg.sv
package dbgarb_pkg;

    typedef enum logic [1:0] {
        RT_ONCHIP  = 2'd0,
        RT_OFFCHIP = 2'd1,
        RT_REGWIN  = 2'd2
    } route_t;

    typedef struct packed {
        logic [31:0] addr;
        logic [31:0] wdata;
        logic        write;
        route_t      route;
    } held_req_t;

    function automatic route_t classify(
        input logic [31:0] addr,
        input logic [31:0] offchip_base,
        input logic [31:0] reg_base,
        input logic        regs_on
    );
        if (regs_on && addr >= reg_base)
            return RT_REGWIN;
        else if (addr >= offchip_base)
            return RT_OFFCHIP;
        else
            return RT_ONCHIP;
    endfunction

endpackage

// File: rtl/dbgarb_req_hold.sv
module dbgarb_req_hold
    import dbgarb_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int NREG = 8,
    parameter logic [31:0] OFFCHIP_BASE = 32'h0000_C000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          dbg_mode,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic          req_write,
    input  logic          done,
    output logic          req_ready,
    output logic          pend,
    output logic [AW-1:0] h_addr,
    output logic [DW-1:0] h_wdata,
    output logic          h_write,
    output route_t        h_route
);
    localparam logic [31:0] REG_BASE = 32'((64'd1 << AW) - 64'(NREG));

    logic   accept;
    route_t in_route;

    assign req_ready = !pend;
    assign accept    = req_valid && req_ready;
    assign in_route  = classify(32'(req_addr), OFFCHIP_BASE, REG_BASE, dbg_mode);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend    <= 1'b0;
            h_addr  <= '0;
            h_wdata <= '0;
            h_write <= 1'b0;
            h_route <= RT_ONCHIP;
        end else if (accept) begin
            pend    <= 1'b1;
            h_addr  <= req_addr;
            h_wdata <= req_wdata;
            h_write <= req_write;
            h_route <= in_route;
        end else if (done) begin
            pend    <= 1'b0;
        end
    end

    // R7: captured request must not change while it waits
    p_hold_stable_r7: assert property (@(posedge clk) disable iff (rst)
        (pend && !done) |=> ($stable(h_addr) && $stable(h_wdata) && $stable(h_write)));

    // R1: a pending request blocks new acceptance
    p_ready_low_r1: assert property (@(posedge clk) disable iff (rst)
        accept |=> !req_ready);

endmodule

// File: rtl/dbgarb_steal_timer.sv
module dbgarb_steal_timer #(
    parameter int TIMEOUT = 128
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic clear,
    output logic expired
);
    localparam int CW = $clog2(TIMEOUT + 1);
    localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT);

    logic [CW-1:0] cnt;

    assign expired = (cnt == LIMIT);

    always_ff @(posedge clk) begin
        if (rst || clear)
            cnt <= '0;
        else if (run && !expired)
            cnt <= cnt + 1'b1;
    end

    // R3: waiting count never passes the window
    p_timer_bound_r3: assert property (@(posedge clk) disable iff (rst)
        cnt <= LIMIT);

endmodule

// File: rtl/dbgarb_regbank.sv
module dbgarb_regbank #(
    parameter int DW = 16,
    parameter int NREG = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [$clog2(NREG)-1:0] idx,
    input  logic [DW-1:0]           wdata,
    output logic [DW-1:0]           rdata
);
    localparam int IW = $clog2(NREG);

    logic [DW-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs[g] <= '0;
            else if (wr_en && idx == IW'(g))
                regs[g] <= wdata;
        end
    end

    assign rdata = regs[idx];

endmodule

// File: rtl/dbgarb_top.sv
module dbgarb_top
    import dbgarb_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int TIMEOUT = 128,
    parameter int NREG = 8,
    parameter logic [31:0] OFFCHIP_BASE = 32'h0000_C000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          dbg_mode,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic          req_write,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    input  logic          core_bus_idle,
    output logic          core_stall,
    output logic          bus_en,
    output logic          bus_we,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata
);
    localparam int IW = $clog2(NREG);

    logic          pend;
    logic [AW-1:0] h_addr;
    logic [DW-1:0] h_wdata;
    logic          h_write;
    route_t        h_route;
    logic          expired;
    logic          go_bus;
    logic          go_reg;
    logic          done;
    logic [DW-1:0] reg_rdata;

    dbgarb_req_hold #(
        .AW(AW), .DW(DW), .NREG(NREG), .OFFCHIP_BASE(OFFCHIP_BASE)
    ) u_hold (
        .clk(clk), .rst(rst), .dbg_mode(dbg_mode),
        .req_valid(req_valid), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_write(req_write),
        .done(done), .req_ready(req_ready), .pend(pend),
        .h_addr(h_addr), .h_wdata(h_wdata), .h_write(h_write),
        .h_route(h_route)
    );

    dbgarb_steal_timer #(.TIMEOUT(TIMEOUT)) u_timer (
        .clk(clk), .rst(rst),
        .run(pend && !done),
        .clear(!pend || done),
        .expired(expired)
    );

    dbgarb_regbank #(.DW(DW), .NREG(NREG)) u_regs (
        .clk(clk), .rst(rst),
        .wr_en(go_reg && h_write),
        .idx(h_addr[IW-1:0]),
        .wdata(h_wdata),
        .rdata(reg_rdata)
    );

    // Decide this cycle's action for the held request
    always_comb begin
        go_reg = pend && (h_route == RT_REGWIN);
        go_bus = pend && (h_route != RT_REGWIN) &&
                 (core_bus_idle || h_route == RT_OFFCHIP || expired);
        done   = go_reg || go_bus;
    end

    assign bus_en     = go_bus;
    assign bus_we     = go_bus && h_write;
    assign bus_addr   = h_addr;
    assign bus_wdata  = h_wdata;
    assign core_stall = go_bus && !core_bus_idle;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= done;
            if (done && !h_write)
                rsp_rdata <= go_reg ? reg_rdata : bus_rdata;
        end
    end

    // R5: a stolen cycle lasts one cycle only
    p_stall_single_r5: assert property (@(posedge clk) disable iff (rst)
        core_stall |=> !core_stall);

    // R5: stall only while the debug side owns a busy bus
    p_stall_busy_r5: assert property (@(posedge clk) disable iff (rst)
        core_stall |-> (bus_en && !core_bus_idle));

    // R4: stealing needs an off-chip target or an expired window
    p_steal_cause_r4: assert property (@(posedge clk) disable iff (rst)
        core_stall |-> (h_route == RT_OFFCHIP || expired));

    // R6: each bus access is answered on the next cycle
    p_rsp_follows_r6: assert property (@(posedge clk) disable iff (rst)
        bus_en |=> rsp_valid);

    // R8: register window traffic never owns the bus
    p_regwin_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (pend && h_route == RT_REGWIN) |-> (!bus_en && !core_stall));

endmodule

// File: tb/tb_dbgarb_top.sv
module tb_dbgarb_top;
    localparam int TIMEOUT = 128;

    logic        clk = 1'b0;
    logic        rst;
    logic        dbg_mode;
    logic        req_valid;
    logic        req_ready;
    logic [15:0] req_addr;
    logic [15:0] req_wdata;
    logic        req_write;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic        core_bus_idle;
    logic        core_stall;
    logic        bus_en;
    logic        bus_we;
    logic [15:0] bus_addr;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata;

    always #10 clk = ~clk;

    dbgarb_top dut (
        .clk(clk), .rst(rst), .dbg_mode(dbg_mode),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_write(req_write),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .core_bus_idle(core_bus_idle), .core_stall(core_stall),
        .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    // Environment memory, aliased on the low address byte
    logic [15:0] mem [256];
    assign bus_rdata = mem[bus_addr[7:0]];
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 256; i++) mem[i] <= 16'(i * 3 + 16'h0100);
        end else if (bus_en && bus_we) begin
            mem[bus_addr[7:0]] <= bus_wdata;
        end
    end

    int errors = 0;
    int checks = 0;

    // Drive values applied each cycle
    logic        d_rst, d_mode, d_valid, d_write, d_idle;
    logic [15:0] d_addr, d_wdata;

    // Reference model state
    bit          m_pend;
    int          m_wait;
    logic [15:0] m_addr, m_wd;
    bit          m_we;
    int          m_route;   // 0 on-chip, 1 off-chip, 2 register window
    bit          m_win;     // top window address with debug mode low
    bit          m_rsp, m_rsp_rd, m_rsp_reg;
    logic [15:0] m_rsp_data;
    logic [15:0] m_regs [8];

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic cycle();
        bit          go_bus, go_reg, n_rsp, n_rd, n_reg;
        logic [15:0] n_data;
        string       tag;
        @(negedge clk);
        rst = d_rst; dbg_mode = d_mode; req_valid = d_valid;
        req_addr = d_addr; req_wdata = d_wdata; req_write = d_write;
        core_bus_idle = d_idle;
        #5;
        go_reg = m_pend && m_route == 2;
        go_bus = m_pend && m_route != 2 &&
                 (d_idle || m_route == 1 || m_wait == TIMEOUT);
        n_rsp = 0; n_rd = 0; n_reg = 0; n_data = '0;
        if (!d_rst) begin
            chk("R1", "req_ready", req_ready, !m_pend);
            if (go_reg) tag = "R8";
            else if (m_pend && m_win) tag = "R9";
            else if (m_pend && m_route == 1) tag = "R4";
            else if (m_pend && m_wait == TIMEOUT && !d_idle) tag = "R3";
            else tag = "R2";
            chk(tag, "bus_en", bus_en, go_bus);
            chk("R5", "core_stall", core_stall, go_bus && !d_idle);
            chk("R6", "rsp_valid", rsp_valid, m_rsp);
            if (m_rsp && m_rsp_rd)
                chk(m_rsp_reg ? "R8" : "R6", "rsp_rdata", rsp_rdata, m_rsp_data);
            if (go_bus) begin
                chk("R7", "bus_addr", bus_addr, m_addr);
                chk("R7", "bus_we", bus_we, m_we);
                if (m_we) chk("R7", "bus_wdata", bus_wdata, m_wd);
            end
            if (go_reg || go_bus) begin
                n_rsp = 1; n_rd = !m_we; n_reg = go_reg;
                n_data = go_reg ? m_regs[m_addr[2:0]] : mem[m_addr[7:0]];
            end
        end
        @(posedge clk);
        #1;
        if (d_rst) begin
            m_pend = 0; m_wait = 0; m_rsp = 0; m_rsp_rd = 0; m_rsp_reg = 0;
            for (int i = 0; i < 8; i++) m_regs[i] = '0;
        end else begin
            m_rsp = n_rsp; m_rsp_rd = n_rd; m_rsp_reg = n_reg;
            if (n_rsp && n_rd) m_rsp_data = n_data;
            if (go_reg && m_we) m_regs[m_addr[2:0]] = m_wd;
            if (m_pend) begin
                if (go_reg || go_bus) begin m_pend = 0; m_wait = 0; end
                else m_wait++;
            end else if (d_valid) begin
                m_pend = 1; m_wait = 0;
                m_addr = d_addr; m_wd = d_wdata; m_we = d_write;
                m_win = !d_mode && d_addr >= 16'hFFF8;
                if (d_mode && d_addr >= 16'hFFF8) m_route = 2;
                else if (d_addr >= 16'hC000) m_route = 1;
                else m_route = 0;
            end
        end
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) cycle();
    endtask

    task automatic send(input logic [15:0] a, input logic [15:0] w, input logic wr);
        d_valid = 1; d_addr = a; d_wdata = w; d_write = wr;
        cycle();
        d_valid = 0;
    endtask

    task automatic finish_up();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_up();
    end

    initial begin
        d_rst = 1; d_mode = 0; d_valid = 0; d_write = 0; d_idle = 0;
        d_addr = '0; d_wdata = '0;
        run(3);
        // R10: reset state seen at the ports
        #2;
        chk("R10", "req_ready", req_ready, 1);
        chk("R10", "rsp_valid", rsp_valid, 0);
        chk("R10", "bus_en", bus_en, 0);
        chk("R10", "core_stall", core_stall, 0);
        d_rst = 0;
        cycle();
        chk("R10", "rsp_valid after", rsp_valid, 0);

        // R2: idle core, read served in first pending cycle
        d_idle = 1; send(16'h0010, 0, 0); run(3);
        // R2: write waits through busy cycles, then uses idle slot
        d_idle = 0; send(16'h0020, 16'hBEEF, 1); run(5);
        d_idle = 1; run(2);
        send(16'h0020, 0, 0); run(2);
        // R3: permanently busy core, steal after the window
        d_idle = 0; send(16'h0030, 0, 0); run(TIMEOUT + 6);
        // R3: idle arriving exactly on the last waiting cycle
        send(16'h0031, 0, 0); run(TIMEOUT - 1);
        d_idle = 1; run(3);
        // R4: off-chip read with busy core, and off-chip write with idle core
        d_idle = 0; send(16'hC100, 0, 0); run(3);
        d_idle = 1; send(16'hD004, 16'h5A5A, 1); run(3);
        // R8: register window with debug mode, busy core
        d_mode = 1; d_idle = 0;
        send(16'hFFFA, 16'h1234, 1); run(2);
        send(16'hFFFA, 0, 0); run(2);
        send(16'hFFF8, 0, 0); run(2);
        // R9: same addresses without debug mode go to the bus
        d_mode = 0; send(16'hFFFA, 0, 0); run(3);
        // R1: valid held high with changing data while pending
        d_valid = 1; d_write = 0; d_addr = 16'h0040;
        cycle();
        for (int k = 0; k < 8; k++) begin
            d_addr = 16'(16'h0050 + k);
            cycle();
        end
        d_idle = 1; run(2);
        d_valid = 0; run(3);
        // R2: alternating idle pattern
        d_idle = 0; send(16'h0060, 0, 0);
        for (int k = 0; k < 6; k++) begin
            d_idle = k[0];
            cycle();
        end
        run(2);
        finish_up();
    end

endmodule